// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the column addresses an SDRAM controller presents for that burst, one per accepted beat. A request is a start strobe, the starting column, and the low nibble of the mode-register image. That nibble holds a 3-bit length code in bits 2:0 and the ordering-type bit in bit 3. The block decodes the length and the ordering, then walks the burst. In sequential order the low address bits count upward and wrap inside the burst-sized window. In interleaved order the low bits are the starting bits XORed with the beat index. A full-page burst is a sequential walk over the whole page that wraps at the page end, and it runs until a stop request ends it.

Addresses leave on a valid/ready stream. `col_valid` is high for every beat of an active burst. A beat is consumed only on a clock edge where `col_valid` and `col_ready` are both high. While `col_ready` is low, the address and last flag hold still and the burst does not advance. A start request is taken only when the block is idle, and an illegal length/type combination is reported on a one-cycle error pulse instead of starting a burst. Command sequencing and data paths belong to the surrounding controller.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `col_valid`, `busy` and `cfg_err` are all low.
- R2: A `start` while idle with a legal mode makes `col_valid` and `busy` high on the next clock, with `col_addr` equal to `start_col` for the first beat.
- R3: Length codes 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. `col_last` is high on the final beat only, and `col_valid` is low on the clock after that beat is accepted.
- R4: With mode bit 3 = 0 (sequential) and a fixed length BL, beat n carries the starting column with its low log2(BL) bits replaced by (start low bits + n) mod BL. The upper column bits stay unchanged.
- R5: With mode bit 3 = 1 (interleaved) and a fixed length BL, beat n carries the starting column with its low log2(BL) bits replaced by (start low bits XOR n).
- R6: Length code 111 with bit 3 = 0 is a full-page burst. The address steps by one per beat modulo 2^COL_W, wrapping from the top column to 0, and `col_last` never rises.
- R7: `stop` high while `col_valid` is high ends the burst. A beat handshaking in that cycle is still consumed, and on the next clock `col_valid` and `busy` are low.
- R8: Length codes 100, 101 and 110, and code 111 with bit 3 = 1, are illegal. A `start` carrying one of these, while the block is idle, raises `cfg_err` for exactly one clock on the next edge and starts no burst.
- R9: While `col_valid` is high and `col_ready` is low, `col_addr` and `col_last` hold their values and the beat index does not advance.
- R10: A `start` while `busy` is high is ignored. The running burst's address sequence and length are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst request strobe, taken when idle |
| start_col | input | COL_W | First column of the burst |
| mode_bits | input | 4 | Mode image nibble: [2:0] length code, [3] ordering type |
| stop | input | 1 | Ends the active burst |
| col_ready | input | 1 | Consumer accepts the current beat |
| col_valid | output | 1 | A beat address is offered |
| col_addr | output | COL_W | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one of a fixed-length burst |
| busy | output | 1 | A burst is in progress |
| cfg_err | output | 1 | One-cycle pulse: illegal mode on a start request |

## Verification
The bench aims at window wrap-around, using start columns whose low bits sit near the top of the burst window. A design that carried into the upper bits would leave the window instead of folding back to its base. Interleaved bursts from non-aligned starts catch a design that added where it should XOR. Full-page bursts that cross the page end, and stops issued mid-burst, catch an address that runs past the page, a stray last flag, or a burst that outlives its stop. The bench also drives a random ready pattern, illegal modes and starts issued during a burst. A design that advanced without a handshake, launched a burst on a bad mode, or restarted on a busy start would deliver a sequence that differs from the scoreboard's.

// File: rtl/burst_colgen_pkg.sv
package burst_colgen_pkg;

  // Field positions inside the mode nibble; the decoder depends on them.
  localparam int LEN_LSB  = 0;
  localparam int LEN_W    = 3;
  localparam int TYPE_BIT = 3;

  typedef enum logic [2:0] {
    LEN_ONE  = 3'b000,
    LEN_TWO  = 3'b001,
    LEN_FOUR = 3'b010,
    LEN_EIGHT= 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic legal;
    logic full;
    logic ilv;
  } burst_kind_t;

endpackage

// File: rtl/sdram_bcg_mode_decode.sv
module sdram_bcg_mode_decode
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [3:0]       mode_bits,
  output burst_kind_t      kind,
  output logic [COL_W-1:0] win_mask
);

  logic [LEN_W-1:0] code;
  logic             ilv_sel;

  assign code    = mode_bits[LEN_LSB +: LEN_W];
  assign ilv_sel = mode_bits[TYPE_BIT];

  always_comb begin
    kind.ilv   = ilv_sel;
    kind.full  = 1'b0;
    kind.legal = 1'b0;
    case (code)
      LEN_ONE, LEN_TWO, LEN_FOUR, LEN_EIGHT: kind.legal = 1'b1;
      LEN_PAGE: begin
        kind.full  = 1'b1;
        kind.legal = ~ilv_sel;
      end
      default: kind.legal = 1'b0;
    endcase
  end

  // Window mask: low log2(BL) bits set, or every bit for a page walk.
  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign win_mask[i] = kind.full |
                         (~code[2] & (i < {30'd0, code[1:0]}));
  end

endmodule

// File: rtl/sdram_bcg_beat_ctr.sv
module sdram_bcg_beat_ctr #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  output logic [CNT_W-1:0] beat
);

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      beat <= '0;
    end else if (advance) begin
      beat <= beat + 1'b1;
    end
  end

endmodule

// File: rtl/sdram_bcg_addr_map.sv
module sdram_bcg_addr_map #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] win_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);

  logic [COL_W-1:0] step_sum;

  assign step_sum = base + beat;

  // Bits outside the window come from the base; inside, either the
  // wrapped sum (sequential) or the XOR pattern (interleaved).
  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign addr[i] = win_mask[i] ? (ilv ? (base[i] ^ beat[i]) : step_sum[i])
                                 : base[i];
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import burst_colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [3:0]       mode_bits,
  input  logic             stop,
  input  logic             col_ready,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             busy,
  output logic             cfg_err
);

  burst_kind_t      kind;
  logic [COL_W-1:0] new_mask;

  logic             busy_q;
  logic             err_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             ilv_q;
  logic             full_q;
  logic [COL_W-1:0] beat;

  logic accept;
  logic fire;
  logic finish;

  sdram_bcg_mode_decode #(.COL_W(COL_W)) u_dec (
    .mode_bits (mode_bits),
    .kind      (kind),
    .win_mask  (new_mask)
  );

  assign accept = start & ~busy_q;
  assign fire   = busy_q & col_ready;
  assign finish = (fire & col_last) | (busy_q & stop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      err_q <= accept & ~kind.legal;
      if (accept) begin
        busy_q <= kind.legal;
        base_q <= start_col;
        mask_q <= new_mask;
        ilv_q  <= kind.ilv;
        full_q <= kind.full;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  sdram_bcg_beat_ctr #(.CNT_W(COL_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .advance (fire),
    .beat    (beat)
  );

  sdram_bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base     (base_q),
    .beat     (beat),
    .win_mask (mask_q),
    .ilv      (ilv_q),
    .addr     (col_addr)
  );

  assign col_valid = busy_q;
  assign col_last  = busy_q & ~full_q & (beat == mask_q);
  assign busy      = busy_q;
  assign cfg_err   = err_q;

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic             col_ready,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             col_last,
  input logic             busy,
  input logic             cfg_err
);

  AST_LAUNCH_OR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (col_valid ^ cfg_err)); // R2

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_ready && col_last) |=> !col_valid); // R3

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && stop) |=> (!col_valid && !busy)); // R7

  AST_ERR_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !col_valid); // R8

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_ready && !stop) |=>
      (col_valid && $stable(col_addr) && $stable(col_last))); // R9

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .stop      (stop),
  .col_ready (col_ready),
  .col_valid (col_valid),
  .col_addr  (col_addr),
  .col_last  (col_last),
  .busy      (busy),
  .cfg_err   (cfg_err)
);

// File: tb/sdram_burst_colgen_test.sv
`timescale 1ns/1ps
module sdram_burst_colgen_test;

  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [3:0]       mode_bits = '0;
  logic             stop = 1'b0;
  logic             col_ready = 1'b0;
  logic             col_valid;
  logic [COL_W-1:0] col_addr;
  logic             col_last;
  logic             busy;
  logic             cfg_err;

  always #2 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .mode_bits(mode_bits), .stop(stop), .col_ready(col_ready),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
    .busy(busy), .cfg_err(cfg_err)
  );

  int total = 0;
  int bad   = 0;
  bit rdy_random = 1'b0;

  logic [COL_W-1:0] exp_addr_q[$];
  logic             exp_last_q[$];
  string            exp_req_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference ordering computed arithmetically from the requirements.
  function automatic int ref_addr(input int s, input int bl, input bit ilv, input int n);
    int low  = s % bl;
    int high = s - low;
    int pos  = ilv ? (low ^ (n % bl)) : ((low + n) % bl);
    return high + pos;
  endfunction

  // Monitor: pick ready, then compare any beat that handshakes this cycle.
  always @(negedge clk) begin
    col_ready = rdy_random ? ($urandom % 3 != 0) : 1'b1;
    #1;
    if (rst_n && col_valid && col_ready) begin
      if (exp_addr_q.size() == 0) begin
        check(1'b0, "R3", "unexpected beat addr", int'(col_addr), -1);
      end else begin
        logic [COL_W-1:0] ea;
        logic             el;
        string            rq;
        ea = exp_addr_q.pop_front();
        el = exp_last_q.pop_front();
        rq = exp_req_q.pop_front();
        check(col_addr == ea, rq, "beat addr", int'(col_addr), int'(ea));
        check(col_last == el, rq, "beat last", int'(col_last), int'(el));
      end
    end
  end

  task automatic push_beats(input int col, input int code, input bit ilv,
                            input int nbeats, input string req);
    int bl = (code == 7) ? PAGE : (1 << code);
    for (int n = 0; n < nbeats; n++) begin
      exp_addr_q.push_back(COL_W'(ref_addr(col, bl, ilv, n)));
      exp_last_q.push_back((code != 7) && (n == bl - 1));
      exp_req_q.push_back(req);
    end
  endtask

  task automatic launch(input int col, input int code, input bit ilv);
    @(negedge clk);
    start     = 1'b1;
    start_col = COL_W'(col);
    mode_bits = {ilv, 3'(code)};
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    do @(negedge clk); while (exp_addr_q.size() != 0);
    @(negedge clk);
    #2;
    check(!col_valid && !busy, req, "idle after burst", int'(col_valid), 0);
  endtask

  task automatic fixed_burst(input int col, input int code, input bit ilv,
                             input string req);
    push_beats(col, code, ilv, 1 << code, req);
    launch(col, code, ilv);
    wait_idle(req);
  endtask

  // Stop issued on the k-th offered beat with ready held high.
  task automatic stopped_burst(input int col, input int code, input int k,
                               input string req);
    rdy_random = 1'b0;
    push_beats(col, code, 1'b0, k, req);
    launch(col, code, 1'b0);
    repeat (k - 1) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    #2;
    check(!col_valid && !busy, "R7", "ended by stop", int'(col_valid), 0);
    check(exp_addr_q.size() == 0, "R7", "beats left", exp_addr_q.size(), 0);
  endtask

  task automatic bad_mode(input int code, input bit ilv);
    launch(100, code, ilv);
    #2;
    check(cfg_err === 1'b1, "R8", "error pulse", int'(cfg_err), 1);
    check(!col_valid && !busy, "R8", "no burst", int'(col_valid), 0);
    @(negedge clk);
    #2;
    check(cfg_err === 1'b0, "R8", "error one cycle", int'(cfg_err), 0);
    check(!col_valid, "R8", "still idle", int'(col_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!col_valid && !busy && !cfg_err, "R1", "reset outputs",
          int'({col_valid, busy, cfg_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3: single beat and each fixed length, ready always high
    fixed_burst(5, 0, 1'b0, "R2");
    fixed_burst(7, 1, 1'b0, "R3");
    // R4: sequential wrap inside the window, upper bits fixed
    fixed_burst(10'h1F6, 2, 1'b0, "R4");
    fixed_burst(10'h02D, 3, 1'b0, "R4");
    // R5: interleaved from unaligned starts
    fixed_burst(10'h15B, 3, 1'b1, "R5");
    fixed_burst(10'h3FE, 2, 1'b1, "R5");
    fixed_burst(10'h0C1, 1, 1'b1, "R5");

    // R9: random back-pressure over every fixed length and type
    rdy_random = 1'b1;
    for (int code = 0; code < 4; code++) begin
      for (int t = 0; t < 2; t++) begin
        fixed_burst(int'($urandom % PAGE), code, t[0], t[0] ? "R5" : "R9");
      end
    end
    fixed_burst(10'h3FF, 3, 1'b0, "R9");

    // R10: start during a burst is ignored
    push_beats(10'h2A3, 3, 1'b0, 8, "R10");
    launch(10'h2A3, 3, 1'b0);
    @(negedge clk);
    start = 1'b1; start_col = 10'd500; mode_bits = 4'b1000;
    @(negedge clk);
    start = 1'b0;
    wait_idle("R10");

    // R6: full page wrapping past the top column, then stopped
    stopped_burst(PAGE - 4, 7, 8, "R6");
    stopped_burst(3, 7, 2, "R6");
    // R7: stop cutting a fixed burst short
    stopped_burst(10'h120, 3, 3, "R7");

    // R8: illegal codes
    bad_mode(4, 1'b0);
    bad_mode(6, 1'b0);
    bad_mode(7, 1'b1);
    // a legal burst still works after errors
    fixed_burst(9, 2, 1'b1, "R5");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule